// File: doc/BRIEF.md
# Window Threshold Interrupt Generator

The block watches a 16-bit light-channel result stream and raises a level interrupt when a sampled result falls outside a programmable window. The window has a lower bound and an upper bound. Each bound is a 16-bit value held in two byte registers, which the command decoder loads through a simple byte write port. The lower bound fires on less-than-or-equal. The upper bound fires only on strictly-greater. This asymmetry is part of the contract.

The interrupt is sticky. Once set, it stays set until the command decoder pulses the clear input. A global enable gates the setting of new interrupts but has no effect on clearing. A result is compared only in the cycle its valid strobe is high, and it is always compared against the threshold values held before that cycle's edge.

Top module: `win_irq_top`

## Requirements
- R1: All four threshold bytes reset to 00h. So after reset, with interrupts enabled, a result of 0 sets the interrupt through the lower bound and a result of 1 sets it through the upper bound.
- R2: Writing address 2h loads bits 7:0 of the lower bound and address 3h loads bits 15:8. Writing 4h loads bits 7:0 of the upper bound and 5h loads bits 15:8.
- R3: A valid result less than or equal to the lower bound sets the interrupt. A result equal to the bound counts.
- R4: A valid result strictly greater than the upper bound sets the interrupt. A result equal to the upper bound does not.
- R5: A valid result strictly inside the window (above the lower bound and not above the upper bound) does not set the interrupt.
- R6: When result_valid_i is low, the result input has no effect on the interrupt.
- R7: irq_o is low after reset and, once set, stays high in every cycle without a clear.
- R8: A clear pulse with no simultaneous trigger drives irq_o low on the following cycle.
- R9: When a trigger and a clear arrive in the same cycle, irq_o is high on the following cycle.
- R10: With int_en_i low, no result sets the interrupt, but a clear still drives irq_o low.
- R11: Writes to any address other than 2h, 3h, 4h and 5h leave both bounds unchanged.
- R12: irq_o rises on the cycle after the triggering valid result is sampled. A threshold write in the same cycle as a valid result takes effect only for later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| result_i | input | 16 | Channel result word |
| result_valid_i | input | 1 | Strobe marking a new result |
| wr_en_i | input | 1 | Register byte write enable |
| wr_addr_i | input | 4 | Register address of the write |
| wr_data_i | input | 8 | Byte written |
| int_en_i | input | 1 | Allows new interrupts to latch |
| int_clr_i | input | 1 | Clear pulse from the command decoder |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted threshold byte shows up only when a result lands near the affected bound. For this reason the bench places results exactly on each bound and one count either side, and uses bound values whose two bytes differ so that swapped bytes are caught. A wrong latch state shows on irq_o one cycle after the causing edge and persists until the next clear, so every check reads the pin in the first cycle the change is due and again after idle cycles. Mistakes in the priority between trigger and clear, or in the enable gating, appear only when those inputs coincide, so each of those overlaps is driven directly.

// File: rtl/wthr_pkg.sv
package wthr_pkg;
  localparam int unsigned RESULT_W  = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned REG_ADDR_W = 4;
  localparam int unsigned LO_BASE_A = 2;
  localparam int unsigned HI_BASE_A = 4;
endpackage

// File: rtl/thr_regs.sv
module thr_regs #(
  parameter int unsigned DATA_W  = wthr_pkg::RESULT_W,
  parameter int unsigned BYTE_W  = wthr_pkg::BYTE_W,
  parameter int unsigned ADDR_W  = wthr_pkg::REG_ADDR_W,
  parameter int unsigned LO_BASE = wthr_pkg::LO_BASE_A,
  parameter int unsigned HI_BASE = wthr_pkg::HI_BASE_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] thr_lo_o,
  output logic [DATA_W-1:0] thr_hi_o
);
  localparam int unsigned NB = DATA_W / BYTE_W;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] LoA = ADDR_W'(LO_BASE + g);
    localparam logic [ADDR_W-1:0] HiA = ADDR_W'(HI_BASE + g);
    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == LoA) lo_q <= wr_data_i;
        if (wr_addr_i == HiA) hi_q <= wr_data_i;
      end
    end

    assign thr_lo_o[g*BYTE_W +: BYTE_W] = lo_q;
    assign thr_hi_o[g*BYTE_W +: BYTE_W] = hi_q;
  end

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(thr_lo_o) && $stable(thr_hi_o)));
endmodule

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int unsigned DATA_W = wthr_pkg::RESULT_W
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  output logic              hit_o
);
  logic below, above;
  // asymmetric window: inclusive low, exclusive high
  assign below = (result_i <= thr_lo_i);
  assign above = (result_i >  thr_hi_i);
  assign hit_o = below | above;
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic hit_i,
  input  logic en_i,
  input  logic clr_i,
  output logic irq_o
);
  logic set_irq, irq_q;

  assign set_irq = sample_i & hit_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (set_irq) irq_q <= 1'b1;  // trigger beats clear
    else if (clr_i)   irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  assert_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(sample_i && hit_i && en_i)) |=> !irq_o);
  assert_race_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && hit_i && en_i) |=> irq_o);
  assert_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !en_i) |=> !irq_o);
  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !sample_i) |=> !irq_o);
endmodule

// File: rtl/win_irq_top.sv
module win_irq_top #(
  parameter int unsigned DATA_W  = wthr_pkg::RESULT_W,
  parameter int unsigned BYTE_W  = wthr_pkg::BYTE_W,
  parameter int unsigned ADDR_W  = wthr_pkg::REG_ADDR_W,
  parameter int unsigned LO_BASE = wthr_pkg::LO_BASE_A,
  parameter int unsigned HI_BASE = wthr_pkg::HI_BASE_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_valid_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              int_en_i,
  input  logic              int_clr_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] thr_lo, thr_hi;
  logic              hit;

  thr_regs #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .thr_lo_o(thr_lo), .thr_hi_o(thr_hi)
  );

  win_cmp #(.DATA_W(DATA_W)) u_cmp (
    .result_i(result_i), .thr_lo_i(thr_lo), .thr_hi_i(thr_hi), .hit_o(hit)
  );

  irq_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sample_i(result_valid_i), .hit_i(hit), .en_i(int_en_i),
    .clr_i(int_clr_i), .irq_o(irq_o)
  );

  assert_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_i && int_en_i && (result_i <= thr_lo)) |=> irq_o);
  assert_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_i && int_en_i && (result_i > thr_hi)) |=> irq_o);
  assert_in_win_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && int_clr_i && (result_i > thr_lo) && (result_i <= thr_hi)) |=> !irq_o);
endmodule

// File: tb/win_irq_top_tb.sv
`timescale 1ns/1ps
module win_irq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] result = '0;
  logic        valid = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        int_en = 1'b0;
  logic        int_clr = 1'b0;
  logic        irq;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  win_irq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result), .result_valid_i(valid),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .int_en_i(int_en), .int_clr_i(int_clr), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic sample(logic [15:0] v);
    result = v; valid = 1'b1;
    tick();
    valid = 1'b0;
  endtask

  task automatic clear();
    int_clr = 1'b1;
    tick();
    int_clr = 1'b0;
  endtask

  task automatic set_bounds(logic [15:0] lo, logic [15:0] hi);
    wr(4'h2, lo[7:0]); wr(4'h3, lo[15:8]);
    wr(4'h4, hi[7:0]); wr(4'h5, hi[15:8]);
  endtask

  task automatic t_reset();
    check("R7 reset low", irq, 1'b0);
    int_en = 1'b1;
    sample(16'h0000);
    check("R1 zero lower bound", irq, 1'b1);
    clear();
    check("R8 clear", irq, 1'b0);
    sample(16'h0001);
    check("R1 zero upper bound", irq, 1'b1);
    clear();
  endtask

  task automatic t_bounds();
    set_bounds(16'h0100, 16'h8000);
    sample(16'h0100); check("R3 equal low", irq, 1'b1); clear();
    sample(16'h00FF); check("R3 below low", irq, 1'b1); clear();
    sample(16'h0101); check("R5 just inside", irq, 1'b0);
    sample(16'h8000); check("R4 equal high", irq, 1'b0);
    sample(16'h4000); check("R5 mid window", irq, 1'b0);
    sample(16'h8001); check("R4 above high", irq, 1'b1); clear();
    wr(4'h2, 8'h34); wr(4'h3, 8'h12);
    sample(16'h1235); check("R2 byte order low", irq, 1'b0);
    sample(16'h1234); check("R2 low bound 1234", irq, 1'b1); clear();
    wr(4'h4, 8'h01); wr(4'h5, 8'h70);
    sample(16'h7001); check("R2 high bound equal", irq, 1'b0);
    sample(16'h7002); check("R2 high bound above", irq, 1'b1); clear();
  endtask

  task automatic t_valid();
    result = 16'h0000; valid = 1'b0;
    repeat (4) tick();
    check("R6 no strobe", irq, 1'b0);
  endtask

  task automatic t_hold();
    sample(16'h0000);
    repeat (5) tick();
    check("R7 held", irq, 1'b1);
    clear();
    check("R8 cleared", irq, 1'b0);
  endtask

  task automatic t_race();
    result = 16'h0000; valid = 1'b1; int_clr = 1'b1;
    tick();
    valid = 1'b0; int_clr = 1'b0;
    check("R9 trigger over clear from low", irq, 1'b1);
    result = 16'hFFFF; valid = 1'b1; int_clr = 1'b1;
    tick();
    valid = 1'b0; int_clr = 1'b0;
    check("R9 trigger over clear while high", irq, 1'b1);
    clear();
  endtask

  task automatic t_enable();
    int_en = 1'b0;
    sample(16'h0000);
    check("R10 disabled low trigger", irq, 1'b0);
    sample(16'hFFFF);
    check("R10 disabled high trigger", irq, 1'b0);
    int_en = 1'b1;
    sample(16'h0000);
    int_en = 1'b0;
    check("R10 set before disable", irq, 1'b1);
    clear();
    check("R10 clear while disabled", irq, 1'b0);
    int_en = 1'b1;
  endtask

  task automatic t_ignore();
    wr(4'h0, 8'hFF); wr(4'h1, 8'hFF); wr(4'h6, 8'hFF);
    wr(4'h7, 8'hFF); wr(4'hA, 8'hFF); wr(4'hF, 8'hFF);
    sample(16'h1235); check("R11 low bound kept", irq, 1'b0);
    sample(16'h7001); check("R11 high bound kept", irq, 1'b0);
  endtask

  task automatic t_timing();
    result = 16'h1000; valid = 1'b1;
    wr_en = 1'b1; wr_addr = 4'h3; wr_data = 8'h00;
    #1;
    check("R12 not before edge", irq, 1'b0);
    tick();
    valid = 1'b0; wr_en = 1'b0;
    check("R12 old bound used", irq, 1'b1);
    clear();
    sample(16'h1000);
    check("R12 new bound later", irq, 1'b0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_bounds();
    t_valid();
    t_hold();
    t_race();
    t_enable();
    t_ignore();
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog irq actual=%b expected=done", irq);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule